// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps the program order of instructions that execute out of order. Each instruction that issues claims the next free slot at the tail of a circular queue and gets the slot number back as its tag. Execution units later post a result against that tag, which marks the slot complete. Until then, and afterwards until retirement, younger consumers can read the stored value through a lookup port. Results reach architectural state only when their slot is at the head. Up to two completed slots leave per clock, oldest first.

A retiring slot produces a register write, a memory write or no write at all, depending on its kind. A store's memory address arrives with its result. A branch that execution found to be mispredicted, or any instruction that recorded an exception, retires alone. When it does, the block raises a flush that empties the whole queue and supplies the address where fetch must resume. For a misprediction that is the corrected branch target. For an exception it is a fixed handler address.

Top module: `inorder_retire_buf`

## Requirements
- R1: Out of reset the queue is empty: `alloc_ready_o` is 1, `alloc_tag_o` is 0, and no retire slot, flush or exception output is active.
- R2: An accepted allocation takes the tail slot, and `alloc_tag_o` shows the tail slot before the edge. Tags run upward and wrap from DEPTH-1 to 0. A freshly allocated slot reads as not complete.
- R3: With DEPTH slots occupied, `alloc_ready_o` is 0. An allocation request in that state is dropped and consumes no slot.
- R4: A result write to an occupied tag marks the slot complete and stores the value. From the next cycle `rd_ready_o`/`rd_value_o` show it for that tag. A result write to an unoccupied tag changes nothing.
- R5: Retirement happens only from the head and only when the head slot is complete. A complete younger slot waits behind an incomplete older one.
- R6: Kind encoding is 2'b00 register operation, 2'b01 store, 2'b10 branch, 2'b11 no-destination operation. A retiring register operation raises `cmtN_reg_we_o` with the register number given at allocation as destination. A retiring store raises `cmtN_mem_we_o` with the address given at result write. Branches and 2'b11 retire with no write. The mispredict flag is ignored on non-branch kinds.
- R7: When the two oldest slots are both complete, both retire in the same clock, with the older one on slot 0.
- R8: A retiring branch flagged mispredicted appears on slot 0 with no write. It raises `flush_o` with `redirect_o` equal to its target and leaves slot 1 unused. The next cycle the queue is empty and the next tag follows the branch.
- R9: An exception flag is held in its slot and raised on `excp_o` only when that slot retires at the head. The slot writes nothing, `flush_o` rises, `redirect_o` equals HANDLER_PC, and all younger slots are discarded.
- R10: Slot 1 is never used for an instruction that carries an exception or a branch misprediction; it waits to reach the head.
- R11: While `flush_o` is high, `alloc_ready_o` is 0 even when the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Request to allocate a slot |
| alloc_kind_i | input | 2 | Instruction kind of the request |
| alloc_dest_i | input | ADDR_W | Destination register number (register operations) |
| alloc_ready_o | output | 1 | Allocation will be accepted this cycle |
| alloc_tag_o | output | log2(DEPTH) | Slot number that the request receives |
| wb_valid_i | input | 1 | Result write |
| wb_tag_i | input | log2(DEPTH) | Slot the result belongs to |
| wb_value_i | input | DATA_W | Result value |
| wb_addr_i | input | ADDR_W | Memory address (stores) |
| wb_mispred_i | input | 1 | Branch was mispredicted |
| wb_target_i | input | ADDR_W | Corrected successor address of the branch |
| wb_excp_i | input | 1 | Instruction raised an exception |
| rd_tag_i | input | log2(DEPTH) | Slot to look up for an operand |
| rd_ready_o | output | 1 | Looked-up slot is occupied and complete |
| rd_value_o | output | DATA_W | Value of the looked-up slot |
| cmt0_valid_o | output | 1 | Head slot retires |
| cmt0_reg_we_o | output | 1 | Slot 0 register write |
| cmt0_mem_we_o | output | 1 | Slot 0 memory write |
| cmt0_dest_o | output | ADDR_W | Slot 0 register number or address |
| cmt0_value_o | output | DATA_W | Slot 0 value |
| cmt1_valid_o | output | 1 | Second-oldest slot retires |
| cmt1_reg_we_o | output | 1 | Slot 1 register write |
| cmt1_mem_we_o | output | 1 | Slot 1 memory write |
| cmt1_dest_o | output | ADDR_W | Slot 1 register number or address |
| cmt1_value_o | output | DATA_W | Slot 1 value |
| flush_o | output | 1 | Discard every in-flight instruction |
| excp_o | output | 1 | Exception taken by the retiring head |
| redirect_o | output | ADDR_W | Fetch restart address while flushing |

## Verification
Retirement can meet allocation in one clock. The bench posts a result to the head and, within that same cycle, requests a new slot. It then checks that the old head left while the new slot took the next tag and stays pending. Retirement can also meet a flush. The bench lets a mispredicted branch and an excepting instruction reach the head while younger slots are already complete. It checks that slot 1 stays idle, that allocation is refused during the flush even with room left, and that the discarded tags no longer read as complete afterwards.

// File: rtl/retq_pkg.sv
package retq_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10,
        KIND_NOP    = 2'b11
    } kind_e;

endpackage

// File: rtl/retq_ptrs.sv
module retq_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [1:0]       pop_cnt_i,
    input  logic             flush_i,
    output logic [IDX_W-1:0] head_idx_o,
    output logic [IDX_W-1:0] head1_idx_o,
    output logic [IDX_W-1:0] tail_idx_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [CNT_W-1:0] head;
        logic [CNT_W-1:0] tail;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        ptr_d.head = ptr_q.head + {{(CNT_W-2){1'b0}}, pop_cnt_i};
        if (flush_i) begin
            ptr_d.tail = ptr_d.head;
        end else begin
            ptr_d.tail = ptr_q.tail + {{(CNT_W-1){1'b0}}, push_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign head_idx_o  = ptr_q.head[IDX_W-1:0];
    assign head1_idx_o = ptr_q.head[IDX_W-1:0] + 1'b1;
    assign tail_idx_o  = ptr_q.tail[IDX_W-1:0];
    assign count_o     = ptr_q.tail - ptr_q.head;
    assign empty_o     = (ptr_q.tail == ptr_q.head);
    assign full_o      = (ptr_q.tail[IDX_W-1:0] == ptr_q.head[IDX_W-1:0]) &&
                         (ptr_q.tail[IDX_W] != ptr_q.head[IDX_W]);

    assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CNT_W'(DEPTH));

    assert_no_push_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o);

    assert_pop_within_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {{(CNT_W-2){1'b0}}, pop_cnt_i} <= count_o);

    assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> empty_o);

endmodule

// File: rtl/retq_slots.sv
module retq_slots
    import retq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int NRD    = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              alloc_we_i,
    input  logic [IDX_W-1:0]  alloc_idx_i,
    input  kind_e             alloc_kind_i,
    input  logic [ADDR_W-1:0] alloc_dest_i,
    input  logic              wb_we_i,
    input  logic [IDX_W-1:0]  wb_idx_i,
    input  logic [DATA_W-1:0] wb_value_i,
    input  logic [ADDR_W-1:0] wb_addr_i,
    input  logic              wb_mispred_i,
    input  logic [ADDR_W-1:0] wb_target_i,
    input  logic              wb_excp_i,
    input  logic [IDX_W-1:0]  rd_idx_i     [NRD],
    output kind_e             rd_kind_o    [NRD],
    output logic [ADDR_W-1:0] rd_dest_o    [NRD],
    output logic [DATA_W-1:0] rd_value_o   [NRD],
    output logic              rd_ready_o   [NRD],
    output logic              rd_mispred_o [NRD],
    output logic              rd_excp_o    [NRD],
    output logic [ADDR_W-1:0] rd_target_o  [NRD]
);

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] dest;
        logic [DATA_W-1:0] value;
        logic              ready;
        logic              mispred;
        logic              excp;
        logic [ADDR_W-1:0] target;
    } slot_t;

    slot_t [DEPTH-1:0] slots_d, slots_q;

    always_comb begin
        slots_d = slots_q;
        if (alloc_we_i) begin
            slots_d[alloc_idx_i]       = '0;
            slots_d[alloc_idx_i].kind  = alloc_kind_i;
            slots_d[alloc_idx_i].dest  = alloc_dest_i;
        end
        if (wb_we_i) begin
            slots_d[wb_idx_i].value   = wb_value_i;
            slots_d[wb_idx_i].ready   = 1'b1;
            slots_d[wb_idx_i].excp    = wb_excp_i;
            slots_d[wb_idx_i].mispred = wb_mispred_i &&
                                        (slots_q[wb_idx_i].kind == KIND_BRANCH);
            slots_d[wb_idx_i].target  = wb_target_i;
            if (slots_q[wb_idx_i].kind == KIND_STORE) begin
                slots_d[wb_idx_i].dest = wb_addr_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_kind_o[p]    = slots_q[rd_idx_i[p]].kind;
        assign rd_dest_o[p]    = slots_q[rd_idx_i[p]].dest;
        assign rd_value_o[p]   = slots_q[rd_idx_i[p]].value;
        assign rd_ready_o[p]   = slots_q[rd_idx_i[p]].ready;
        assign rd_mispred_o[p] = slots_q[rd_idx_i[p]].mispred;
        assign rd_excp_o[p]    = slots_q[rd_idx_i[p]].excp;
        assign rd_target_o[p]  = slots_q[rd_idx_i[p]].target;
    end

    assert_alloc_wb_apart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alloc_we_i && wb_we_i) |-> (alloc_idx_i != wb_idx_i));

    assert_alloc_clears_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_we_i |=> !slots_q[$past(alloc_idx_i)].ready);

endmodule

// File: rtl/retq_retire.sv
module retq_retire
    import retq_pkg::*;
#(
    parameter int                 ADDR_W     = 32,
    parameter int                 CNT_W      = 4,
    parameter logic [ADDR_W-1:0]  HANDLER_PC = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  count_i,
    input  kind_e             h0_kind_i,
    input  logic              h0_ready_i,
    input  logic              h0_excp_i,
    input  logic              h0_mispred_i,
    input  logic [ADDR_W-1:0] h0_target_i,
    input  kind_e             h1_kind_i,
    input  logic              h1_ready_i,
    input  logic              h1_excp_i,
    input  logic              h1_mispred_i,
    output logic              c0_valid_o,
    output logic              c0_reg_we_o,
    output logic              c0_mem_we_o,
    output logic              c1_valid_o,
    output logic              c1_reg_we_o,
    output logic              c1_mem_we_o,
    output logic [1:0]        pop_cnt_o,
    output logic              flush_o,
    output logic              excp_o,
    output logic [ADDR_W-1:0] redirect_o
);

    logic h0_stop, h1_stop;

    always_comb begin
        h0_stop = h0_excp_i || ((h0_kind_i == KIND_BRANCH) && h0_mispred_i);
        h1_stop = h1_excp_i || ((h1_kind_i == KIND_BRANCH) && h1_mispred_i);

        c0_valid_o  = (count_i != '0) && h0_ready_i;
        c0_reg_we_o = c0_valid_o && !h0_excp_i && (h0_kind_i == KIND_REG);
        c0_mem_we_o = c0_valid_o && !h0_excp_i && (h0_kind_i == KIND_STORE);

        c1_valid_o  = c0_valid_o && !h0_stop && (count_i >= CNT_W'(2)) &&
                      h1_ready_i && !h1_stop;
        c1_reg_we_o = c1_valid_o && (h1_kind_i == KIND_REG);
        c1_mem_we_o = c1_valid_o && (h1_kind_i == KIND_STORE);

        pop_cnt_o   = {1'b0, c0_valid_o} + {1'b0, c1_valid_o};

        flush_o     = c0_valid_o && h0_stop;
        excp_o      = c0_valid_o && h0_excp_i;
        if (excp_o) begin
            redirect_o = HANDLER_PC;
        end else if (flush_o) begin
            redirect_o = h0_target_i;
        end else begin
            redirect_o = '0;
        end
    end

    assert_slot1_needs_slot0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c1_valid_o |-> c0_valid_o);

    assert_flush_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> !c1_valid_o);

    assert_one_write_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(c0_reg_we_o && c0_mem_we_o) && !(c1_reg_we_o && c1_mem_we_o));

    assert_excp_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        excp_o |-> (!c0_reg_we_o && !c0_mem_we_o));

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
    import retq_pkg::*;
#(
    parameter int                DEPTH      = 8,
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] HANDLER_PC = 32'h0000_0100,
    localparam int               IDX_W      = $clog2(DEPTH),
    localparam int               CNT_W      = IDX_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              alloc_valid_i,
    input  logic [1:0]        alloc_kind_i,
    input  logic [ADDR_W-1:0] alloc_dest_i,
    output logic              alloc_ready_o,
    output logic [IDX_W-1:0]  alloc_tag_o,
    input  logic              wb_valid_i,
    input  logic [IDX_W-1:0]  wb_tag_i,
    input  logic [DATA_W-1:0] wb_value_i,
    input  logic [ADDR_W-1:0] wb_addr_i,
    input  logic              wb_mispred_i,
    input  logic [ADDR_W-1:0] wb_target_i,
    input  logic              wb_excp_i,
    input  logic [IDX_W-1:0]  rd_tag_i,
    output logic              rd_ready_o,
    output logic [DATA_W-1:0] rd_value_o,
    output logic              cmt0_valid_o,
    output logic              cmt0_reg_we_o,
    output logic              cmt0_mem_we_o,
    output logic [ADDR_W-1:0] cmt0_dest_o,
    output logic [DATA_W-1:0] cmt0_value_o,
    output logic              cmt1_valid_o,
    output logic              cmt1_reg_we_o,
    output logic              cmt1_mem_we_o,
    output logic [ADDR_W-1:0] cmt1_dest_o,
    output logic [DATA_W-1:0] cmt1_value_o,
    output logic              flush_o,
    output logic              excp_o,
    output logic [ADDR_W-1:0] redirect_o
);

    localparam int NRD = 3;
    localparam int P_H0 = 0;
    localparam int P_H1 = 1;
    localparam int P_LK = 2;

    logic [IDX_W-1:0] head_idx, head1_idx, tail_idx;
    logic [CNT_W-1:0] count;
    logic             full, empty;
    logic [1:0]       pop_cnt;
    logic             alloc_fire, wb_fire;

    logic [IDX_W-1:0]  rp_idx     [NRD];
    kind_e             rp_kind    [NRD];
    logic [ADDR_W-1:0] rp_dest    [NRD];
    logic [DATA_W-1:0] rp_value   [NRD];
    logic              rp_ready   [NRD];
    logic              rp_mispred [NRD];
    logic              rp_excp    [NRD];
    logic [ADDR_W-1:0] rp_target  [NRD];

    function automatic logic occupied(input logic [IDX_W-1:0] tag,
                                      input logic [IDX_W-1:0] head,
                                      input logic [CNT_W-1:0] cnt);
        logic [IDX_W-1:0] off;
        off = tag - head;
        return {1'b0, off} < cnt;
    endfunction

    assign alloc_ready_o = !full && !flush_o;
    assign alloc_fire    = alloc_valid_i && alloc_ready_o;
    assign alloc_tag_o   = tail_idx;
    assign wb_fire       = wb_valid_i && occupied(wb_tag_i, head_idx, count);

    assign rp_idx[P_H0] = head_idx;
    assign rp_idx[P_H1] = head1_idx;
    assign rp_idx[P_LK] = rd_tag_i;

    retq_ptrs #(
        .DEPTH (DEPTH)
    ) ptrs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (alloc_fire),
        .pop_cnt_i   (pop_cnt),
        .flush_i     (flush_o),
        .head_idx_o  (head_idx),
        .head1_idx_o (head1_idx),
        .tail_idx_o  (tail_idx),
        .count_o     (count),
        .full_o      (full),
        .empty_o     (empty)
    );

    retq_slots #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NRD    (NRD)
    ) slots_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .alloc_we_i   (alloc_fire),
        .alloc_idx_i  (tail_idx),
        .alloc_kind_i (kind_e'(alloc_kind_i)),
        .alloc_dest_i (alloc_dest_i),
        .wb_we_i      (wb_fire),
        .wb_idx_i     (wb_tag_i),
        .wb_value_i   (wb_value_i),
        .wb_addr_i    (wb_addr_i),
        .wb_mispred_i (wb_mispred_i),
        .wb_target_i  (wb_target_i),
        .wb_excp_i    (wb_excp_i),
        .rd_idx_i     (rp_idx),
        .rd_kind_o    (rp_kind),
        .rd_dest_o    (rp_dest),
        .rd_value_o   (rp_value),
        .rd_ready_o   (rp_ready),
        .rd_mispred_o (rp_mispred),
        .rd_excp_o    (rp_excp),
        .rd_target_o  (rp_target)
    );

    retq_retire #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .HANDLER_PC (HANDLER_PC)
    ) retire_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .count_i      (count),
        .h0_kind_i    (rp_kind[P_H0]),
        .h0_ready_i   (rp_ready[P_H0]),
        .h0_excp_i    (rp_excp[P_H0]),
        .h0_mispred_i (rp_mispred[P_H0]),
        .h0_target_i  (rp_target[P_H0]),
        .h1_kind_i    (rp_kind[P_H1]),
        .h1_ready_i   (rp_ready[P_H1]),
        .h1_excp_i    (rp_excp[P_H1]),
        .h1_mispred_i (rp_mispred[P_H1]),
        .c0_valid_o   (cmt0_valid_o),
        .c0_reg_we_o  (cmt0_reg_we_o),
        .c0_mem_we_o  (cmt0_mem_we_o),
        .c1_valid_o   (cmt1_valid_o),
        .c1_reg_we_o  (cmt1_reg_we_o),
        .c1_mem_we_o  (cmt1_mem_we_o),
        .pop_cnt_o    (pop_cnt),
        .flush_o      (flush_o),
        .excp_o       (excp_o),
        .redirect_o   (redirect_o)
    );

    assign cmt0_dest_o  = rp_dest[P_H0];
    assign cmt0_value_o = rp_value[P_H0];
    assign cmt1_dest_o  = rp_dest[P_H1];
    assign cmt1_value_o = rp_value[P_H1];

    assign rd_ready_o = rp_ready[P_LK] && occupied(rd_tag_i, head_idx, count);
    assign rd_value_o = rp_value[P_LK];

    assert_empty_no_retire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty |-> !cmt0_valid_o);

    assert_flush_quiets_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> (!cmt0_valid_o && !flush_o));

    assert_flush_blocks_alloc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> !alloc_ready_o);

endmodule

// File: tb/inorder_retire_buf_tb_top.sv
module inorder_retire_buf_tb_top;

    localparam int          DEPTH   = 8;
    localparam int          DATA_W  = 32;
    localparam int          ADDR_W  = 32;
    localparam logic [31:0] HANDLER = 32'h0000_0100;
    localparam int          IDX_W   = $clog2(DEPTH);

    localparam logic [1:0] K_REG = 2'b00;
    localparam logic [1:0] K_ST  = 2'b01;
    localparam logic [1:0] K_BR  = 2'b10;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              alloc_valid_i = 1'b0;
    logic [1:0]        alloc_kind_i = '0;
    logic [ADDR_W-1:0] alloc_dest_i = '0;
    logic              alloc_ready_o;
    logic [IDX_W-1:0]  alloc_tag_o;
    logic              wb_valid_i = 1'b0;
    logic [IDX_W-1:0]  wb_tag_i = '0;
    logic [DATA_W-1:0] wb_value_i = '0;
    logic [ADDR_W-1:0] wb_addr_i = '0;
    logic              wb_mispred_i = 1'b0;
    logic [ADDR_W-1:0] wb_target_i = '0;
    logic              wb_excp_i = 1'b0;
    logic [IDX_W-1:0]  rd_tag_i = '0;
    logic              rd_ready_o;
    logic [DATA_W-1:0] rd_value_o;
    logic              cmt0_valid_o, cmt0_reg_we_o, cmt0_mem_we_o;
    logic [ADDR_W-1:0] cmt0_dest_o;
    logic [DATA_W-1:0] cmt0_value_o;
    logic              cmt1_valid_o, cmt1_reg_we_o, cmt1_mem_we_o;
    logic [ADDR_W-1:0] cmt1_dest_o;
    logic [DATA_W-1:0] cmt1_value_o;
    logic              flush_o, excp_o;
    logic [ADDR_W-1:0] redirect_o;

    int checks = 0;
    int errors = 0;

    always #10 clk_i = ~clk_i;

    inorder_retire_buf #(
        .DEPTH      (DEPTH),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .HANDLER_PC (HANDLER)
    ) dut_i (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #2;
    endtask

    task automatic do_alloc(input logic [1:0] kind, input logic [31:0] dest,
                            output logic [IDX_W-1:0] tag, output logic acc);
        @(negedge clk_i);
        alloc_valid_i = 1'b1;
        alloc_kind_i  = kind;
        alloc_dest_i  = dest;
        #1;
        tag = alloc_tag_o;
        acc = alloc_ready_o;
        @(posedge clk_i);
        #2;
        alloc_valid_i = 1'b0;
    endtask

    task automatic do_wb(input logic [IDX_W-1:0] tag, input logic [31:0] value,
                         input logic [31:0] addr, input logic mis,
                         input logic [31:0] tgt, input logic ex);
        @(negedge clk_i);
        wb_valid_i   = 1'b1;
        wb_tag_i     = tag;
        wb_value_i   = value;
        wb_addr_i    = addr;
        wb_mispred_i = mis;
        wb_target_i  = tgt;
        wb_excp_i    = ex;
        @(posedge clk_i);
        #2;
        wb_valid_i   = 1'b0;
        wb_mispred_i = 1'b0;
        wb_excp_i    = 1'b0;
    endtask

    task automatic look(input logic [IDX_W-1:0] tag);
        rd_tag_i = tag;
        #1;
    endtask

    task automatic scen_reset();
        chk("R1", "alloc_ready", alloc_ready_o, 1);
        chk("R1", "alloc_tag", alloc_tag_o, 0);
        chk("R1", "cmt0_valid", cmt0_valid_o, 0);
        chk("R1", "flush/excp", {flush_o, excp_o}, 0);
    endtask

    task automatic scen_dual_retire();
        logic [IDX_W-1:0] t;
        logic a;
        do_alloc(K_REG, 32'd5, t, a);
        chk("R2", "first tag", t, 0);
        do_alloc(K_ST, 32'd0, t, a);
        chk("R2", "second tag", t, 1);
        do_alloc(K_REG, 32'd7, t, a);
        chk("R2", "third tag", t, 2);
        do_wb(2, 32'hA, 0, 0, 0, 0);
        chk("R5", "younger ready no retire", cmt0_valid_o, 0);
        look(2);
        chk("R4", "lookup ready", rd_ready_o, 1);
        chk("R4", "lookup value", rd_value_o, 32'hA);
        do_wb(1, 32'hB, 32'h40, 0, 0, 0);
        chk("R5", "head pending", cmt0_valid_o, 0);
        do_wb(0, 32'hC, 0, 0, 0, 0);
        chk("R7", "slot0 valid", cmt0_valid_o, 1);
        chk("R6", "slot0 reg write", {cmt0_reg_we_o, cmt0_mem_we_o}, 2'b10);
        chk("R6", "slot0 dest", cmt0_dest_o, 5);
        chk("R6", "slot0 value", cmt0_value_o, 32'hC);
        chk("R7", "slot1 valid", cmt1_valid_o, 1);
        chk("R6", "slot1 mem write", {cmt1_reg_we_o, cmt1_mem_we_o}, 2'b01);
        chk("R6", "slot1 address", cmt1_dest_o, 32'h40);
        chk("R6", "slot1 value", cmt1_value_o, 32'hB);
        tick();
        chk("R7", "third retires next", {cmt0_valid_o, cmt1_valid_o}, 2'b10);
        chk("R6", "third dest", cmt0_dest_o, 7);
        chk("R6", "third value", cmt0_value_o, 32'hA);
        tick();
        chk("R5", "drained", cmt0_valid_o, 0);
        chk("R2", "next tag", alloc_tag_o, 3);
    endtask

    task automatic scen_stray_wb();
        do_wb(5, 32'h55, 0, 0, 0, 0);
        look(5);
        chk("R4", "unoccupied stays idle", rd_ready_o, 0);
        chk("R4", "no retire from stray", cmt0_valid_o, 0);
    endtask

    task automatic scen_full_mispredict();
        logic [IDX_W-1:0] t;
        logic a;
        do_alloc(K_REG, 32'd1, t, a);
        chk("R2", "tag after drain", t, 3);
        do_alloc(K_BR, 32'd0, t, a);
        for (int i = 0; i < 6; i++) begin
            do_alloc(K_REG, 32'd10 + i, t, a);
        end
        chk("R2", "wrapped tag", t, 2);
        look(5);
        chk("R2", "fresh slot not ready", rd_ready_o, 0);
        chk("R3", "full refuses", alloc_ready_o, 0);
        do_alloc(K_REG, 32'd9, t, a);
        chk("R3", "request while full dropped", a, 0);
        do_wb(3, 32'd1, 0, 0, 0, 0);
        chk("R6", "head retires reg", {cmt0_valid_o, cmt0_reg_we_o}, 2'b11);
        chk("R6", "head dest", cmt0_dest_o, 1);
        tick();
        do_alloc(K_REG, 32'd20, t, a);
        chk("R3", "dropped request took no slot", {a, t}, {1'b1, 3'd3});
        do_wb(5, 32'h5, 0, 0, 0, 0);
        chk("R5", "blocked by branch", cmt0_valid_o, 0);
        do_wb(4, 32'h0, 0, 1, 32'h200, 0);
        chk("R8", "branch retires", cmt0_valid_o, 1);
        chk("R8", "branch writes nothing", {cmt0_reg_we_o, cmt0_mem_we_o}, 0);
        chk("R8", "flush", flush_o, 1);
        chk("R8", "redirect", redirect_o, 32'h200);
        chk("R8", "slot1 idle", cmt1_valid_o, 0);
        chk("R8", "no exception", excp_o, 0);
        tick();
        chk("R8", "empty after flush", alloc_ready_o, 1);
        chk("R8", "tag follows branch", alloc_tag_o, 5);
        chk("R8", "flush ends", {flush_o, cmt0_valid_o}, 0);
        look(5);
        chk("R8", "younger discarded", rd_ready_o, 0);
    endtask

    task automatic scen_exception();
        logic [IDX_W-1:0] t;
        logic a;
        do_alloc(K_REG, 32'd2, t, a);
        chk("R9", "tag", t, 5);
        do_alloc(K_ST, 32'd0, t, a);
        do_alloc(K_REG, 32'd3, t, a);
        do_wb(6, 32'h66, 32'h80, 0, 0, 1);
        chk("R9", "held until head", excp_o, 0);
        do_wb(7, 32'h7, 0, 0, 0, 0);
        do_wb(5, 32'h5, 0, 0, 0, 0);
        chk("R9", "older retires first", {cmt0_valid_o, cmt0_reg_we_o}, 2'b11);
        chk("R9", "older dest", cmt0_dest_o, 2);
        chk("R10", "excepting one not in slot1", cmt1_valid_o, 0);
        chk("R9", "not yet raised", excp_o, 0);
        tick();
        chk("R9", "raised at head", {excp_o, flush_o}, 2'b11);
        chk("R9", "handler redirect", redirect_o, HANDLER);
        chk("R9", "no store write", {cmt0_mem_we_o, cmt0_reg_we_o}, 0);
        chk("R11", "alloc blocked in flush", alloc_ready_o, 0);
        tick();
        chk("R9", "tag after exception", alloc_tag_o, 7);
        look(7);
        chk("R9", "younger dropped", rd_ready_o, 0);
        chk("R9", "exception cleared", excp_o, 0);
    endtask

    task automatic scen_overlap();
        logic [IDX_W-1:0] t;
        logic a;
        do_alloc(K_REG, 32'd4, t, a);
        chk("R2", "tag", t, 7);
        do_wb(7, 32'h9, 0, 0, 0, 0);
        chk("R5", "head retires", cmt0_dest_o, 4);
        do_alloc(K_REG, 32'd6, t, a);
        chk("R2", "alloc alongside retire", {a, t}, {1'b1, 3'd0});
        chk("R5", "new slot pending", cmt0_valid_o, 0);
        chk("R2", "tail advanced", alloc_tag_o, 1);
        do_wb(0, 32'h11, 0, 0, 0, 0);
        chk("R6", "wrapped slot retires", {cmt0_valid_o, cmt0_reg_we_o}, 2'b11);
        chk("R6", "wrapped dest", cmt0_dest_o, 6);
        chk("R6", "wrapped value", cmt0_value_o, 32'h11);
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        #2;
        scen_reset();
        scen_dual_retire();
        scen_stray_wb();
        scen_full_mispredict();
        scen_exception();
        scen_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule